// File: doc/BRIEF.md
# Double-Buffered Serial DAC Code Loader

This block is the digital front end of a 14-bit voltage-output DAC. A host writes a fixed 16-bit word over a three-wire serial link: an active-low select, a serial clock and a data line. The word's top fourteen bits are the new code, sent most significant bit first. Its two trailing sub-bits should be zero. The block oversamples the serial pins on its own system clock. It counts the serial clock rising edges in each frame and shifts the data into an input register. When the frame is accepted, it moves the code into the output latch that drives the converter.

Two update paths exist. In three-wire mode, the latch takes the new code as select goes high. In four-wire mode, the code waits in the input register until a separate active-low load strobe falls while select is high. A frame whose bit count is not exactly sixteen is rejected and reported. At reset, the latch holds the code for the lowest output: all zeros for unipolar use, or 0x2000 for bipolar use, where codes are two's complement and 0x2000 is negative full scale.

Top module: `dac_serial_front`

## Requirements
- R1: While `rst` is high the latch loads 14'h0000 when `bipolar_i` is 0 and 14'h2000 when it is 1; `frame_err_o` and `subbit_warn_o` clear, and no update pulse is produced by reset.
- R2: A frame is the data sampled on serial clock rising edges between select falling and select rising; with exactly 16 edges the first 14 bits (first bit = bit 13) form the code, and in three-wire mode it reaches `code_o` after select rises.
- R3: `update_o` is high for exactly one system clock cycle whenever `code_o` takes a different value, and stays low when a frame rewrites the value already held.
- R4: A frame with a count other than 16 edges (short or long) sets `frame_err_o` and leaves `code_o` unchanged; the next 16-edge frame clears `frame_err_o`.
- R5: Sub-bits (the last two bits of a frame) never affect `code_o`; a 16-edge frame with non-zero sub-bits sets `subbit_warn_o`, which stays set until reset.
- R6: In four-wire mode (`four_wire_i`=1) select rising does not change `code_o`; a later falling edge of `load_n_i` while select is high transfers the held code.
- R7: In four-wire mode a `load_n_i` falling edge while select is low, or with no accepted frame waiting, leaves `code_o` unchanged.
- R8: In three-wire mode `load_n_i` has no effect on `code_o` or `update_o`.
- R9: Serial clock edges while select is high are neither shifted nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Serial select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| load_n_i | input | 1 | Load strobe, active low, four-wire mode only |
| four_wire_i | input | 1 | 1 selects strobe-driven update, 0 select-driven |
| bipolar_i | input | 1 | Chooses the reset code |
| code_o | output | 14 | DAC latch value |
| update_o | output | 1 | One-cycle pulse on latch change |
| frame_err_o | output | 1 | Last frame had a wrong bit count |
| subbit_warn_o | output | 1 | Sticky non-zero sub-bit flag |

## Verification
The bound checker covers several rules on every cycle. It checks that the reset code matches the polarity input and that no pulse fires at reset. It also checks that each latch change comes with exactly one single-cycle pulse and that the pulse never fires without a change. A rejected frame must leave the latch untouched, and the warning flag must never drop outside reset. Other behaviour depends on the shape of the serial frames, so only the bench scenarios can show it. This covers bit order, short and long frame rejection, edges ignored outside a frame, the two update modes, and strobes that arrive too early or with nothing waiting.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    localparam int DATA_W  = 14;
    localparam int SUB_W   = 2;
    localparam int FRAME_W = DATA_W + SUB_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1) + 1;

    typedef logic [DATA_W-1:0] code_t;

    typedef struct packed {
        code_t            data;
        logic [SUB_W-1:0] sub;
        logic             len_ok;
    } frame_t;

    // Lowest-output code: zero for unipolar, most negative two's complement for bipolar
    function automatic code_t floor_code(input logic bipolar);
        code_t c;
        c = '0;
        if (bipolar) c[DATA_W-1] = 1'b1;
        return c;
    endfunction
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter
    import dacfe_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_n,
    input  logic   sclk,
    input  logic   sdi,
    output logic   done_o,
    output frame_t frame_o
);
    logic               cs_q;
    logic               sclk_q;
    logic [FRAME_W-1:0] sreg;
    logic [CNT_W-1:0]   cnt;
    logic               cs_fall, cs_rise, sclk_rise;

    assign cs_fall   = cs_q & ~cs_n;
    assign cs_rise   = ~cs_q & cs_n;
    assign sclk_rise = ~sclk_q & sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q    <= 1'b1;
            sclk_q  <= 1'b0;
            sreg    <= '0;
            cnt     <= '0;
            done_o  <= 1'b0;
            frame_o <= '0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
            done_o <= 1'b0;
            if (cs_fall) begin
                cnt  <= '0;
                sreg <= '0;
            end else if (!cs_n && sclk_rise) begin
                sreg <= {sreg[FRAME_W-2:0], sdi};
                if (cnt != '1) cnt <= cnt + 1'b1;
            end
            if (cs_rise) begin
                done_o         <= 1'b1;
                frame_o.data   <= sreg[FRAME_W-1 -: DATA_W];
                frame_o.sub    <= sreg[SUB_W-1:0];
                frame_o.len_ok <= (cnt == CNT_W'(FRAME_W));
            end
        end
    end
endmodule

// File: rtl/dacfe_latch.sv
module dacfe_latch
    import dacfe_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   done,
    input  frame_t frame,
    input  logic   cs_n,
    input  logic   load_n,
    input  logic   four_wire,
    input  logic   bipolar,
    output code_t  code_o,
    output logic   update_o,
    output logic   frame_err_o,
    output logic   warn_o
);
    logic  load_q;
    logic  load_fall;
    logic  pend_valid;
    code_t pend_data;
    logic  take;
    code_t take_val;

    assign load_fall = load_q & ~load_n;

    always_comb begin
        take     = 1'b0;
        take_val = code_o;
        if (done && frame.len_ok && !four_wire) begin
            take     = 1'b1;
            take_val = frame.data;
        end else if (four_wire && load_fall && cs_n && pend_valid) begin
            take     = 1'b1;
            take_val = pend_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o      <= floor_code(bipolar);
            update_o    <= 1'b0;
            frame_err_o <= 1'b0;
            warn_o      <= 1'b0;
            pend_valid  <= 1'b0;
            pend_data   <= '0;
            load_q      <= 1'b1;
        end else begin
            load_q   <= load_n;
            update_o <= take && (take_val != code_o);
            if (take) code_o <= take_val;
            if (done) begin
                frame_err_o <= !frame.len_ok;
                if (frame.len_ok && (|frame.sub)) warn_o <= 1'b1;
                pend_valid <= four_wire && frame.len_ok;
                pend_data  <= frame.data;
            end else if (take) begin
                pend_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              load_n_i,
    input  logic              four_wire_i,
    input  logic              bipolar_i,
    output logic [DATA_W-1:0] code_o,
    output logic              update_o,
    output logic              frame_err_o,
    output logic              subbit_warn_o
);
    logic [3:0] pins_s;
    logic       done;
    frame_t     frame;

    dacfe_sync #(.W(4), .STAGES(2), .RST_VAL(4'b1001)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n_i, sclk_i, sdi_i, load_n_i}),
        .q   (pins_s)
    );

    dacfe_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (pins_s[3]),
        .sclk    (pins_s[2]),
        .sdi     (pins_s[1]),
        .done_o  (done),
        .frame_o (frame)
    );

    dacfe_latch u_latch (
        .clk         (clk),
        .rst         (rst),
        .done        (done),
        .frame       (frame),
        .cs_n        (pins_s[3]),
        .load_n      (pins_s[0]),
        .four_wire   (four_wire_i),
        .bipolar     (bipolar_i),
        .code_o      (code_o),
        .update_o    (update_o),
        .frame_err_o (frame_err_o),
        .warn_o      (subbit_warn_o)
    );
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker
    import dacfe_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bipolar_i,
    input logic [13:0] code_o,
    input logic        update_o,
    input logic        frame_err_o,
    input logic        subbit_warn_o
);
    p_reset_code_r1: assert property (@(posedge clk)
        $past(rst) |-> (code_o == floor_code($past(bipolar_i))));

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!update_o && !frame_err_o && !subbit_warn_o));

    p_change_pulses_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && code_o != $past(code_o)) |-> update_o);

    p_pulse_means_change_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && update_o) |-> (code_o != $past(code_o)));

    p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
        update_o |=> !update_o);

    p_reject_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(frame_err_o)) |-> $stable(code_o));

    p_warn_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        subbit_warn_o |=> subbit_warn_o);
endmodule

bind dac_serial_front dacfe_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .bipolar_i     (bipolar_i),
    .code_o        (code_o),
    .update_o      (update_o),
    .frame_err_o   (frame_err_o),
    .subbit_warn_o (subbit_warn_o)
);

// File: tb/tb_dac_serial_front.sv
module tb_dac_serial_front;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;

    logic        clk = 0;
    logic        rst = 1;
    logic        cs_n = 1, sclk = 0, sdi = 0, load_n = 1;
    logic        four_wire = 0, bipolar = 0;
    logic [13:0] code;
    logic        update, ferr, warn;

    int checks = 0;
    int errors = 0;
    logic [13:0] expq [$];
    logic        prev_upd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_serial_front dut (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .load_n_i(load_n), .four_wire_i(four_wire), .bipolar_i(bipolar),
        .code_o(code), .update_o(update), .frame_err_o(ferr), .subbit_warn_o(warn)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected codes on each update pulse
    always @(negedge clk) begin
        if (!rst) begin
            if (update) begin
                check(!prev_upd, "R3 pulse longer than one cycle", 1, 0);
                if (expq.size() == 0) begin
                    check(0, "R3 unexpected update", code, 0);
                end else begin
                    logic [13:0] e;
                    e = expq.pop_front();
                    check(code == e, "R2 updated code", code, e);
                end
            end
            prev_upd = update;
        end else begin
            prev_upd = 0;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] pat, input int n);
        cs_n = 0;
        wait_clk(HALF);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = pat[i];
            sclk = 0;
            wait_clk(HALF);
            sclk = 1;
            wait_clk(HALF);
        end
        sclk = 0;
        wait_clk(HALF);
        cs_n = 1;
        wait_clk(2 * HALF);
    endtask

    task automatic send_word(input logic [13:0] d, input logic [1:0] s);
        send_bits({16'h0, d, s}, 16);
    endtask

    task automatic pulse_load();
        load_n = 0;
        wait_clk(HALF);
        load_n = 1;
        wait_clk(2 * HALF);
    endtask

    task automatic settle(input string tag, input logic [13:0] exp_code);
        wait_clk(8);
        check(expq.size() == 0, {tag, " pending update missing"}, expq.size(), 0);
        check(code == exp_code, tag, code, exp_code);
    endtask

    task automatic do_reset();
        rst = 1;
        wait_clk(4);
        rst = 0;
        wait_clk(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 unipolar reset
        check(code == 14'h0000, "R1 unipolar reset code", code, 0);
        check(!ferr && !warn && !update, "R1 flags clear", {ferr, warn, update}, 0);

        // R2 basic three-wire frame
        expq.push_back(14'h1ABC);
        send_word(14'h1ABC, 2'b00);
        settle("R2 three-wire load", 14'h1ABC);
        check(!ferr, "R2 no frame error", ferr, 0);

        // R3 rewrite of same value: no pulse
        send_word(14'h1ABC, 2'b00);
        settle("R3 same value no pulse", 14'h1ABC);

        // R2 bit order
        expq.push_back(14'h0001);
        send_word(14'h0001, 2'b00);
        settle("R2 lsb position", 14'h0001);
        expq.push_back(14'h2000);
        send_word(14'h2000, 2'b00);
        settle("R2 msb first", 14'h2000);

        // R4 short and long frames
        send_bits({17'h0, 15'h5555}, 15);
        settle("R4 short frame keeps code", 14'h2000);
        check(ferr, "R4 short frame flagged", ferr, 1);
        send_bits({15'h0, 17'h1FFFF}, 17);
        settle("R4 long frame keeps code", 14'h2000);
        check(ferr, "R4 long frame flagged", ferr, 1);
        expq.push_back(14'h0F0F);
        send_word(14'h0F0F, 2'b00);
        settle("R4 good frame after error", 14'h0F0F);
        check(!ferr, "R4 error cleared", ferr, 0);

        // R9 clocks while deselected
        sdi = 1;
        for (int k = 0; k < 3; k++) begin
            sclk = 1; wait_clk(HALF);
            sclk = 0; wait_clk(HALF);
        end
        expq.push_back(14'h1234);
        send_word(14'h1234, 2'b00);
        settle("R9 idle edges ignored", 14'h1234);
        check(!ferr, "R9 count unaffected", ferr, 0);

        // R5 sub-bits
        expq.push_back(14'h0555);
        send_word(14'h0555, 2'b11);
        settle("R5 sub-bits ignored", 14'h0555);
        check(warn, "R5 warning set", warn, 1);
        expq.push_back(14'h0AAA);
        send_word(14'h0AAA, 2'b00);
        settle("R5 next frame", 14'h0AAA);
        check(warn, "R5 warning sticky", warn, 1);

        // R8 strobe ignored in three-wire mode
        pulse_load();
        settle("R8 strobe no effect", 14'h0AAA);

        // R6 four-wire
        four_wire = 1;
        send_word(14'h3FFF, 2'b00);
        settle("R6 select rise holds latch", 14'h0AAA);
        expq.push_back(14'h3FFF);
        pulse_load();
        settle("R6 strobe transfers", 14'h3FFF);

        // R7 strobe with nothing waiting
        pulse_load();
        settle("R7 no pending word", 14'h3FFF);

        // R7 strobe while selected
        send_word(14'h0123, 2'b00);
        cs_n = 0;
        wait_clk(HALF);
        load_n = 0;
        wait_clk(HALF);
        load_n = 1;
        wait_clk(HALF);
        for (int i = 15; i >= 0; i--) begin
            sdi = ((i >= 2) && (14'h0456 >> (i - 2)) & 1) ? 1'b1 : 1'b0;
            sclk = 0; wait_clk(HALF);
            sclk = 1; wait_clk(HALF);
        end
        sclk = 0;
        wait_clk(HALF);
        check(code == 14'h3FFF, "R7 strobe during frame ignored", code, 14'h3FFF);
        cs_n = 1;
        wait_clk(2 * HALF);
        settle("R7 after frame still held", 14'h3FFF);
        expq.push_back(14'h0456);
        pulse_load();
        settle("R6 latest frame transferred", 14'h0456);

        // R1 bipolar reset
        four_wire = 0;
        bipolar = 1;
        do_reset();
        check(code == 14'h2000, "R1 bipolar reset code", code, 14'h2000);
        check(!warn && !ferr, "R1 flags cleared by reset", {warn, ferr}, 0);
        wait_clk(8);
        check(expq.size() == 0, "R1 reset gives no pulse", expq.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule